// File: doc/BRIEF.md
# SCAM Selection Discriminator

While a target-side bus controller waits to be selected with SCAM support turned on, this block watches the SEL and BSY lines and times how long each selection stays asserted. A SEL assertion that appears while BSY is low has not been preceded by a won arbitration, so the block treats it as a SCAM selection. An assertion that appears while BSY is still driven follows a normal arbitration and counts as an ordinary selection.

A SCAM selection held for a short minimum time is answered at once with an interrupt pulse. Ordinary selections that end before the long hold limit (4 ms of clock cycles) are dropped without any response. An ordinary selection that stays asserted for the full limit is passed on to the normal select handler through a one-cycle hand-off pulse. An accepted selection of either kind puts the controller in the target role and captures the data bus. Both limits are parameters counted in clock cycles. An enable input stands in for the mode bit that the host sets for the length of the command.

Top module: `scam_sel_discrim`

## Requirements
- R1: While `scam_en` is low, `scam_irq`, `norm_sel` and `tgt_role` stay low whatever the bus lines do.
- R2: A SCAM selection (BSY low in the first cycle that SEL is high) that is held for SCAM_MIN_CYC consecutive sampled cycles makes `scam_irq` high for exactly one cycle, right after the SCAM_MIN_CYC-th rising edge with SEL high.
- R3: A SCAM selection held for fewer than SCAM_MIN_CYC cycles produces no `scam_irq` and no `norm_sel`.
- R4: An ordinary selection (BSY high in the first cycle that SEL is high) held for fewer than HOLD_CYC cycles produces no output at all.
- R5: An ordinary selection held for HOLD_CYC cycles makes `norm_sel` high for exactly one cycle, right after the HOLD_CYC-th rising edge with SEL high, and never raises `scam_irq`.
- R6: An accepted selection sets `tgt_role` in the same cycle as its pulse. `tgt_role` stays high, and later selections produce no pulse, until `scam_en` goes low.
- R7: When SEL drops before a limit is reached, the timer restarts from zero. Two ordinary selections separated by one low cycle, each shorter than HOLD_CYC, produce no `norm_sel` even when their combined length exceeds it.
- R8: On acceptance, `sel_id` takes the value of `data_i` sampled at the accepting edge and holds it until the next acceptance.
- R9: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scam_en | input | 1 | Host-set SCAM wait mode; low clears the block |
| sel_i | input | 1 | Bus SEL line, active high |
| bsy_i | input | 1 | Bus BSY line, active high |
| data_i | input | DW | Bus data lines |
| scam_irq | output | 1 | One-cycle pulse on an accepted SCAM selection |
| norm_sel | output | 1 | One-cycle hand-off pulse to the normal select handler |
| tgt_role | output | 1 | Target role taken after acceptance |
| sel_id | output | DW | Data bus captured at acceptance |

## Verification
Every result comes from one register stage. The SCAM pulse is due right after the SCAM_MIN_CYC-th rising edge with SEL high, and the hand-off pulse right after the HOLD_CYC-th. The bench drives SEL on falling edges and samples at the falling edge after each rising edge, so it records the exact edge index at which a pulse appears and compares it with the parameter. It also keeps sampling for one cycle after SEL drops, so a late or extra pulse is caught. `tgt_role` and `sel_id` are read in the same sample as the pulse.

// File: rtl/scam_sel_discrim.sv
module scam_sel_discrim #(
  parameter int unsigned HOLD_CYC     = 500000,
  parameter int unsigned SCAM_MIN_CYC = 250,
  parameter int unsigned DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scam_en,
  input  logic          sel_i,
  input  logic          bsy_i,
  input  logic [DW-1:0] data_i,
  output logic          scam_irq,
  output logic          norm_sel,
  output logic          tgt_role,
  output logic [DW-1:0] sel_id
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SCAM_LAST = CW'(SCAM_MIN_CYC - 1);

  logic [CW-1:0] cnt;
  logic          kind_q;
  logic          done;

  wire first    = (cnt == '0);
  wire is_scam  = first ? !bsy_i : kind_q;
  wire live     = scam_en && !done && sel_i;
  wire hit_scam = live && is_scam && (cnt == SCAM_LAST);
  wire hit_norm = live && !is_scam && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      kind_q   <= 1'b0;
      done     <= 1'b0;
      scam_irq <= 1'b0;
      norm_sel <= 1'b0;
      tgt_role <= 1'b0;
      sel_id   <= '0;
    end else begin
      scam_irq <= hit_scam;
      norm_sel <= hit_norm;
      if (!scam_en) begin
        cnt      <= '0;
        done     <= 1'b0;
        tgt_role <= 1'b0;
      end else if (!done) begin
        if (!sel_i) begin
          cnt <= '0;
        end else if (hit_scam || hit_norm) begin
          cnt      <= '0;
          done     <= 1'b1;
          tgt_role <= 1'b1;
          sel_id   <= data_i;
        end else begin
          cnt    <= cnt + 1'b1;
          kind_q <= is_scam;
        end
      end
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !scam_en |=> !tgt_role && !scam_irq && !norm_sel); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scam_irq |=> !scam_irq); // R2
  AST_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (scam_irq || norm_sel) |-> $past(sel_i) && $past(scam_en)); // R3
  AST_NORM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    norm_sel |=> !norm_sel); // R5
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scam_irq && norm_sel)); // R5
  AST_ROLE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (scam_irq || norm_sel) |-> tgt_role && !$past(tgt_role)); // R6
  AST_ROLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_role && scam_en) |=> tgt_role); // R6
  AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scam_irq && !norm_sel) |-> $stable(sel_id)); // R8

endmodule

// File: tb/sim_scam_sel_discrim.sv
`timescale 1ns/1ps
module sim_scam_sel_discrim;
  localparam int HOLD = 40;
  localparam int SMIN = 5;
  localparam int NV   = 7;

  localparam logic V_BSY  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int   V_LEN  [NV] = '{SMIN, SMIN-1, 20, HOLD-1, HOLD, 90, 3};
  localparam int   V_IRQ  [NV] = '{1, 0, 1, 0, 0, 0, 0};
  localparam int   V_NORM [NV] = '{0, 0, 0, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0, scam_en = 0, sel = 0, bsy = 0;
  logic [7:0] data = 0;
  logic scam_irq, norm_sel, tgt_role;
  logic [7:0] sel_id;
  int n_chk = 0, n_bad = 0;
  int nirq, nnorm, irq_at, norm_at;

  always #4 clk = ~clk;

  scam_sel_discrim #(.HOLD_CYC(HOLD), .SCAM_MIN_CYC(SMIN), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .scam_en(scam_en), .sel_i(sel), .bsy_i(bsy),
    .data_i(data), .scam_irq(scam_irq), .norm_sel(norm_sel),
    .tgt_role(tgt_role), .sel_id(sel_id));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic watch();
    if (scam_irq) begin nirq++; irq_at = 0; end
    if (norm_sel) begin nnorm++; norm_at = 0; end
  endtask

  task automatic sel_event(input logic b, input int len, input logic [7:0] d);
    nirq = 0; nnorm = 0; irq_at = -1; norm_at = -1;
    @(negedge clk); sel = 1; bsy = b; data = d;
    for (int i = 1; i <= len; i++) begin
      @(posedge clk); @(negedge clk);
      if (scam_irq) begin nirq++; irq_at = i; end
      if (norm_sel) begin nnorm++; norm_at = i; end
      if (i == 1) bsy = 0;
    end
    sel = 0; bsy = 0;
    @(posedge clk); @(negedge clk);
    if (scam_irq) nirq++;
    if (norm_sel) nnorm++;
  endtask

  task automatic rearm();
    @(negedge clk); scam_en = 0;
    @(negedge clk); scam_en = 1;
  endtask

  initial begin
    #(8 * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scam_irq && !norm_sel && !tgt_role && sel_id == 0, "R9 reset", int'(tgt_role), 0);
    rst_n = 1;

    sel_event(1'b0, 10, 8'h11);
    chk(nirq == 0 && nnorm == 0, "R1 disabled scam", nirq + nnorm, 0);
    chk(!tgt_role, "R1 role while disabled", int'(tgt_role), 0);

    scam_en = 1;
    for (int v = 0; v < NV; v++) begin
      sel_event(V_BSY[v], V_LEN[v], 8'(8'h40 + v));
      chk(nirq == V_IRQ[v], V_BSY[v] ? "R4 irq count" : (V_IRQ[v] != 0 ? "R2 irq count" : "R3 irq count"), nirq, V_IRQ[v]);
      chk(nnorm == V_NORM[v], V_NORM[v] != 0 ? "R5 hand-off count" : "R4 hand-off count", nnorm, V_NORM[v]);
      if (V_IRQ[v] != 0) chk(irq_at == SMIN, "R2 irq edge", irq_at, SMIN);
      if (V_NORM[v] != 0) chk(norm_at == HOLD, "R5 hand-off edge", norm_at, HOLD);
      chk(tgt_role == (V_IRQ[v] + V_NORM[v] != 0), "R6 role after event", int'(tgt_role), V_IRQ[v] + V_NORM[v]);
      if (V_IRQ[v] + V_NORM[v] != 0)
        chk(sel_id == 8'(8'h40 + v), "R8 captured id", int'(sel_id), 8'h40 + v);
      rearm();
    end

    sel_event(1'b1, 30, 8'h01);
    sel_event(1'b1, 30, 8'h02);
    chk(nnorm == 0 && nirq == 0, "R7 restart after drop", nnorm, 0);

    sel_event(1'b0, SMIN, 8'hA5);
    chk(tgt_role && sel_id == 8'hA5, "R8 id after scam", int'(sel_id), 8'hA5);
    sel_event(1'b0, SMIN + 2, 8'h5A);
    chk(nirq == 0 && nnorm == 0, "R6 no second pulse", nirq + nnorm, 0);
    chk(tgt_role, "R6 role held", int'(tgt_role), 1);
    chk(sel_id == 8'hA5, "R8 id held", int'(sel_id), 8'hA5);
    @(negedge clk); scam_en = 0;
    @(posedge clk); @(negedge clk);
    chk(!tgt_role, "R1 role cleared by disable", int'(tgt_role), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule